// File: doc/BRIEF.md
# Scaling cascade adder with rectifier

This block is the entry stage of a post-processing datapath. It takes a signed accumulator result and scales it by a power of two. A left shift multiplies it. A right shift divides it, and the shifter rounds on right shifts. The block then adds the scaled value to a 22-bit cascade input in a single signed addition, together with the rounding increment from the shifter. The cascade operand can be replaced by zero, so a lone device works without an upstream neighbour.

The addition wraps modulo 2^22. Two flags report whether the true sum left the signed range on the positive side or the negative side. The wrapped sum can then pass unchanged, or be rectified to its absolute value, or have its negative values clamped to zero. The result and both flags are registered together, and all control comes from static inputs.

Top module: `scl_casc_rect`

## Requirements
- R1: The shift control `shift_ctl` is 5 bits wide. Bit 4 set selects a left shift, and bits 3:0 give the magnitude. A magnitude above 8 acts as 8, and the low 22 bits of the shifted value are kept.
- R2: With bit 4 clear, the accumulator is shifted right arithmetically by n. For n > 0, the rounding increment is bit n-1 of the pre-shift accumulator. For n = 0 and for every left shift, the increment is zero.
- R3: The rounding increment is added in the same 22-bit addition as the second operand, and the sum wraps modulo 2^22.
- R4: When `zero_cas` is 1, the second operand is zero. When it is 0, the second operand is `cas_in`.
- R5: `ovf_pos` is 1 exactly when the scaled value and the second operand both have MSB 0 and the wrapped sum has MSB 1.
- R6: `ovf_neg` is 1 exactly when both operands have MSB 1 and the wrapped sum has MSB 0. Operands of differing sign raise neither flag.
- R7: `rect_mode` selects the output treatment of the sum:
  - 2'b00 and 2'b11 pass the sum unchanged.
  - 2'b01 gives the two's-complement absolute value. The most negative value stays as it is.
  - 2'b10 forces negative values to zero.
- R8: The flags describe the sum before rectification. The result and both flags appear together one clock after their inputs, and the wrapped sum is output even when a flag is set.
- R9: While `rst_n` is low, all outputs are zero. With all controls zero, the output is `acc_in + cas_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_in | input | 22 | Signed accumulator result |
| cas_in | input | 22 | Signed cascade input |
| shift_ctl | input | 5 | Bit 4 = left, bits 3:0 = magnitude |
| zero_cas | input | 1 | 1 = use zero instead of cascade input |
| rect_mode | input | 2 | 00/11 pass, 01 full-wave, 10 half-wave |
| res_out | output | 22 | Registered result |
| ovf_pos | output | 1 | Registered positive overflow flag |
| ovf_neg | output | 1 | Registered negative overflow flag |

## Verification
A rounding increment and an overflow can fall in the same addition. The case that matters most is when the increment alone carries the sum across the positive limit. The bench provokes this with a right shift whose dropped bit is set, against a cascade value just below the maximum, and expects the wrapped sum with `ovf_pos` set. Overflow and rectification can also coincide: an overflowing sum is sent through half-wave rectification, and the bench expects a zero result while the flag still reports the overflow.

// File: rtl/scl_casc_rect_pkg.sv
package scl_casc_rect_pkg;

    typedef enum logic [1:0] {
        RECT_PASS  = 2'b00,
        RECT_FULL  = 2'b01,
        RECT_HALF  = 2'b10,
        RECT_PASS2 = 2'b11
    } rect_mode_e;

endpackage

// File: rtl/scl_shifter.sv
module scl_shifter #(
    parameter int ACC_W     = 22,
    parameter int DATA_W    = 22,
    parameter int MAX_SHIFT = 8,
    parameter int MAG_W     = $clog2(MAX_SHIFT + 1),
    parameter int SHF_W     = MAG_W + 1
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [SHF_W-1:0]  ctl,
    output logic [DATA_W-1:0] scaled,
    output logic              rnd
);
    localparam int EXT_W = ACC_W + MAX_SHIFT;

    logic [EXT_W-1:0]  ext;
    logic [DATA_W-1:0] r_cand [MAX_SHIFT+1];
    logic [DATA_W-1:0] l_cand [MAX_SHIFT+1];
    logic              rb_cand [MAX_SHIFT+1];
    logic [MAG_W-1:0]  mag;
    logic              left;

    assign ext  = {{MAX_SHIFT{acc[ACC_W-1]}}, acc};
    assign left = ctl[SHF_W-1];

    // magnitudes beyond the limit saturate at the limit
    always_comb begin
        if (ctl[MAG_W-1:0] > MAG_W'(MAX_SHIFT)) begin
            mag = MAG_W'(MAX_SHIFT);
        end else begin
            mag = ctl[MAG_W-1:0];
        end
    end

    for (genvar k = 0; k <= MAX_SHIFT; k++) begin : g_cand
        logic [EXT_W-1:0] rsh;
        logic [EXT_W-1:0] lsh;
        assign rsh = EXT_W'($signed(ext) >>> k);
        assign lsh = ext << k;
        assign r_cand[k] = rsh[DATA_W-1:0];
        assign l_cand[k] = lsh[DATA_W-1:0];
        if (k == 0) begin : g_nornd
            assign rb_cand[k] = 1'b0;
        end else begin : g_rnd
            assign rb_cand[k] = acc[k-1];
        end
    end

    always_comb begin
        scaled = '0;
        rnd    = 1'b0;
        for (int i = 0; i <= MAX_SHIFT; i++) begin
            if (mag == MAG_W'(i)) begin
                scaled = left ? l_cand[i] : r_cand[i];
                rnd    = left ? 1'b0 : rb_cand[i];
            end
        end
    end

endmodule

// File: rtl/scl_adder.sv
module scl_adder #(
    parameter int DATA_W = 22
) (
    input  logic [DATA_W-1:0] scaled,
    input  logic              rnd,
    input  logic [DATA_W-1:0] cas,
    input  logic              zero_cas,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_p,
    output logic              ovf_n
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] op;

    assign op  = zero_cas ? '0 : cas;
    assign sum = scaled + op + {{(DATA_W-1){1'b0}}, rnd};

    // sign-pattern overflow: like-signed operands, sum of the other sign
    assign ovf_p = ~scaled[MSB] & ~op[MSB] &  sum[MSB];
    assign ovf_n =  scaled[MSB] &  op[MSB] & ~sum[MSB];

endmodule

// File: rtl/scl_rectifier.sv
module scl_rectifier
    import scl_casc_rect_pkg::*;
#(
    parameter int DATA_W = 22
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] dout
);
    logic       neg;
    rect_mode_e m;

    assign neg = din[DATA_W-1];
    assign m   = rect_mode_e'(mode);

    always_comb begin
        case (m)
            RECT_FULL: dout = neg ? (~din + DATA_W'(1)) : din;
            RECT_HALF: dout = neg ? '0 : din;
            default:   dout = din;
        endcase
    end

endmodule

// File: rtl/scl_casc_rect.sv
module scl_casc_rect #(
    parameter int ACC_W     = 22,
    parameter int DATA_W    = 22,
    parameter int MAX_SHIFT = 8,
    parameter int SHF_W     = $clog2(MAX_SHIFT + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [DATA_W-1:0] cas_in,
    input  logic [SHF_W-1:0]  shift_ctl,
    input  logic              zero_cas,
    input  logic [1:0]        rect_mode,
    output logic [DATA_W-1:0] res_out,
    output logic              ovf_pos,
    output logic              ovf_neg
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              op;
        logic              on;
    } out_t;

    logic [DATA_W-1:0] scaled;
    logic              rnd;
    logic [DATA_W-1:0] sum;
    logic              a_op, a_on;
    logic [DATA_W-1:0] rect;

    out_t out_d, out_q;

    scl_shifter #(
        .ACC_W(ACC_W), .DATA_W(DATA_W), .MAX_SHIFT(MAX_SHIFT),
        .MAG_W(SHF_W - 1), .SHF_W(SHF_W)
    ) u_shf (
        .acc(acc_in), .ctl(shift_ctl), .scaled(scaled), .rnd(rnd)
    );

    scl_adder #(.DATA_W(DATA_W)) u_add (
        .scaled(scaled), .rnd(rnd), .cas(cas_in), .zero_cas(zero_cas),
        .sum(sum), .ovf_p(a_op), .ovf_n(a_on)
    );

    scl_rectifier #(.DATA_W(DATA_W)) u_rect (
        .din(sum), .mode(rect_mode), .dout(rect)
    );

    always_comb begin
        out_d     = out_q;
        out_d.res = rect;
        out_d.op  = a_op;
        out_d.on  = a_on;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_out = out_q.res;
    assign ovf_pos = out_q.op;
    assign ovf_neg = out_q.on;

endmodule

// File: rtl/scl_casc_rect_chk.sv
module scl_casc_rect_chk #(
    parameter int ACC_W  = 22,
    parameter int DATA_W = 22,
    parameter int SHF_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ACC_W-1:0]  acc_in,
    input logic [SHF_W-1:0]  shift_ctl,
    input logic              zero_cas,
    input logic [1:0]        rect_mode,
    input logic [DATA_W-1:0] res_out,
    input logic              ovf_pos,
    input logic              ovf_neg
);
    localparam int MSB = DATA_W - 1;

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_pos, ovf_neg}));

    p_plain_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_cas && shift_ctl == '0 && rect_mode == 2'b00) |=>
        (res_out == $past(acc_in[DATA_W-1:0]) && !ovf_pos && !ovf_neg));

    p_pos_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_mode == 2'b00) |=> (!ovf_pos || res_out[MSB]));

    p_neg_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_mode == 2'b00) |=> (!ovf_neg || !res_out[MSB]));

    p_half_nonneg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_mode == 2'b10) |=> !res_out[MSB]);

    p_full_abs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rect_mode == 2'b01) |=>
        (!res_out[MSB] || res_out == {1'b1, {(DATA_W-1){1'b0}}}));

endmodule

bind scl_casc_rect scl_casc_rect_chk #(
    .ACC_W(ACC_W), .DATA_W(DATA_W), .SHF_W(SHF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .shift_ctl(shift_ctl),
    .zero_cas(zero_cas), .rect_mode(rect_mode), .res_out(res_out),
    .ovf_pos(ovf_pos), .ovf_neg(ovf_neg)
);

// File: tb/scl_casc_rect_test.sv
module scl_casc_rect_test;
    localparam int W = 22;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] acc_in = '0;
    logic [W-1:0] cas_in = '0;
    logic [4:0]   shift_ctl = '0;
    logic         zero_cas = 1'b0;
    logic [1:0]   rect_mode = '0;
    logic [W-1:0] res_out;
    logic         ovf_pos, ovf_neg;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    scl_casc_rect uut (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .cas_in(cas_in),
        .shift_ctl(shift_ctl), .zero_cas(zero_cas), .rect_mode(rect_mode),
        .res_out(res_out), .ovf_pos(ovf_pos), .ovf_neg(ovf_neg)
    );

    function automatic longint wrap(input longint x);
        logic [W-1:0] t;
        t = x[W-1:0];
        return longint'($signed(t));
    endfunction

    task automatic model(input logic [W-1:0] a_i, input logic [W-1:0] c_i,
                         input logic [4:0] sh, input logic z, input logic [1:0] rm,
                         output logic [W-1:0] r, output logic p, output logic n);
        longint a, v, vs, op, s;
        int m, rnd;
        a = longint'($signed(a_i));
        m = int'(sh[3:0]);
        if (m > 8) m = 8;
        rnd = 0;
        if (sh[4]) v = a <<< m;
        else begin
            v = a >>> m;
            if (m > 0) rnd = int'((a >>> (m - 1)) & 1);
        end
        vs = wrap(v);
        op = z ? 0 : wrap(longint'($signed(c_i)));
        s  = wrap(vs + op + rnd);
        p  = (vs >= 0) && (op >= 0) && (s < 0);
        n  = (vs < 0) && (op < 0) && (s >= 0);
        if (rm == 2'b01 && s < 0) s = wrap(-s);
        if (rm == 2'b10 && s < 0) s = 0;
        r = s[W-1:0];
    endtask

    task automatic vec(input logic [W-1:0] a, input logic [W-1:0] c,
                       input logic [4:0] sh, input logic z, input logic [1:0] rm,
                       input string tag);
        logic [W-1:0] er;
        logic ep, en;
        model(a, c, sh, z, rm, er, ep, en);
        acc_in = a; cas_in = c; shift_ctl = sh; zero_cas = z; rect_mode = rm;
        @(negedge clk);
        n_chk++;
        if (res_out !== er || ovf_pos !== ep || ovf_neg !== en) begin
            n_bad++;
            $display("FAIL %s: res=%h ovp=%b ovn=%b expected res=%h ovp=%b ovn=%b",
                     tag, res_out, ovf_pos, ovf_neg, er, ep, en);
        end
    endtask

    localparam logic [W-1:0] MAXP = 22'h1FFFFF;
    localparam logic [W-1:0] MINN = 22'h200000;

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (res_out !== '0 || ovf_pos !== 1'b0 || ovf_neg !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: res=%h ovp=%b ovn=%b expected 0 0 0",
                     res_out, ovf_pos, ovf_neg);
        end
        rst_n = 1'b1;
        vec(22'd100, 22'd23, 5'h00, 1'b0, 2'b00, "R9 default add");
        vec(22'd5, 22'd77, 5'h13, 1'b1, 2'b00, "R1 left 3");
        vec(22'd5, 22'd0, 5'h1C, 1'b1, 2'b00, "R1 left clamp");
        vec(22'd7, 22'd0, 5'h02, 1'b1, 2'b00, "R2 right round up");
        vec(-22'sd7, 22'd0, 5'h02, 1'b1, 2'b00, "R2 negative no round");
        vec(-22'sd6, 22'd0, 5'h02, 1'b1, 2'b00, "R2 negative round");
        vec(22'h3FF, 22'd0, 5'h0F, 1'b1, 2'b00, "R2 right clamp");
        vec(MAXP, 22'd0, 5'h01, 1'b1, 2'b00, "R3 round in sum");
        vec(22'd3, 22'h1FFFFE, 5'h01, 1'b0, 2'b00, "R3 round overflow");
        vec(22'd9, 22'd1000, 5'h00, 1'b1, 2'b00, "R4 zero operand");
        vec(22'd9, 22'd1000, 5'h00, 1'b0, 2'b00, "R4 cascade operand");
        vec(MAXP, 22'd1, 5'h00, 1'b0, 2'b00, "R5 positive overflow");
        vec(MINN, 22'h3FFFFF, 5'h00, 1'b0, 2'b00, "R6 negative overflow");
        vec(MAXP, MINN, 5'h00, 1'b0, 2'b00, "R6 mixed sign");
        vec(22'd10, -22'sd50, 5'h00, 1'b0, 2'b01, "R7 full-wave");
        vec(MINN, 22'd0, 5'h00, 1'b1, 2'b01, "R7 full-wave min");
        vec(22'd10, -22'sd50, 5'h00, 1'b0, 2'b10, "R7 half-wave");
        vec(22'd10, -22'sd50, 5'h00, 1'b0, 2'b11, "R7 pass code 11");
        vec(MAXP, 22'd5, 5'h00, 1'b0, 2'b10, "R8 overflow under half-wave");
        vec(MINN, MINN, 5'h00, 1'b0, 2'b01, "R8 overflow under full-wave");
        for (int i = 0; i < 400; i++) begin
            vec(W'($urandom), W'($urandom), 5'($urandom), 1'($urandom),
                2'($urandom), "R8 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule